// File: doc/BRIEF.md
# Two-Port Shared-Memory Contention Arbiter

This block sits beside a memory that two independent requesters, a left port and a right port, can reach at the same time. Each cycle it looks at each port's select, access-active indication and word address. When both ports are live on the same address, it decides which one may proceed. It then drives an active-low busy flag toward the other port. The flag tells the losing requester to hold its cycle. Writes from that port must be suppressed wherever the flag is consumed.

A single instance serves any number of memory banks placed side by side to widen the data word. Every bank takes its busy inputs from the same two flags, so all banks always agree on one winner. Two banks can never favour opposite ports and stall both sides.

Arrival order is judged in whole clock cycles. A port that was already live on the contested address in the previous cycle beats a port that joins in the current cycle. This covers both ways a contention can form: one port selecting after the addresses already match, or one port moving its address onto the other's. A decision holds until the contention dissolves. When both ports arrive in the same cycle, a fixed rule picks the winner.

Top module: `busy_arbiter`

## Requirements
- R1: When the ports are not in contention in a cycle, both busy flags are high in the following cycle. Contention means both ports are live and their addresses are equal. A port is live when its select and its access-active input are both 1.
- R2: Enable ordering: if the addresses already match and one port turns live one cycle or more before the other, the port that turned live first wins.
- R3: Address ordering: if both ports are live and one port's address moves onto the other port's unchanged address, the port whose address was there first wins.
- R4: Only the losing port's busy flag is driven low. Both flags are never low together, and a flag falls only in the cycle after a contention was present.
- R5: Once a winner is chosen, the decision and both flags stay unchanged for as long as the contention persists.
- R6: The winner completes its access by dropping its select, dropping its access-active input, or moving to another address. The loser's busy flag returns high in the next cycle.
- R7: If both ports arrive in the same cycle, exactly one is granted: the left port when TIE_RIGHT is 0, the right port when it is 1.
- R8: After reset, both busy flags are high and win_valid is 0.
- R9: A port whose access-active input is 0 takes no part in arbitration, even with its select at 1 on a matching address.
- R10: win_valid is 1 exactly while a decision is held. win_right is 1 when that decision favours the right port (the left busy flag is low) and 0 when it favours the left port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l_en | input | 1 | Left port select, active high |
| l_act | input | 1 | Left port access in progress |
| l_addr | input | ADDR_W | Left port word address |
| r_en | input | 1 | Right port select, active high |
| r_act | input | 1 | Right port access in progress |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_n | output | 1 | Busy toward the left port, active low |
| r_busy_n | output | 1 | Busy toward the right port, active low |
| win_valid | output | 1 | A contention decision is held |
| win_right | output | 1 | Held decision favours the right port |

## Verification
The bench builds the arbiter with its defaults: an 11-bit address and left-wins tie breaking (TIE_RIGHT at 0). With these values, the directed cases cover enable-ordered wins from either side, address-ordered wins from either side, same-cycle ties and every way a winner can finish. The random phase draws addresses from only three values, even though the address is 11 bits wide. This makes matches frequent, so long runs of overlapping, held and released contentions occur within a few thousand cycles.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;
  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_LEFT  = 2'd1,
    GNT_RIGHT = 2'd2
  } grant_e;
endpackage

// File: rtl/busy_arb_port_track.sv
module busy_arb_port_track #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              act,
  input  logic [ADDR_W-1:0] addr,
  output logic              live,
  output logic              steady
);
  logic              live_q, live_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_ld;

  always_comb begin
    live    = en & act;
    addr_ld = live;
    live_d  = live;
    addr_d  = addr_ld ? addr : addr_q;
    // steady: this port was already live on the same address last cycle
    steady  = live & live_q & (addr_q == addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      addr_q <= '0;
    end else begin
      live_q <= live_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/busy_arb_grant.sv
module busy_arb_grant
  import busy_arb_pkg::*;
#(
  parameter bit TIE_RIGHT = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   contend,
  input  logic   l_steady,
  input  logic   r_steady,
  output grant_e grant_q
);
  localparam grant_e TIE_GNT = TIE_RIGHT ? GNT_RIGHT : GNT_LEFT;

  grant_e grant_d;

  always_comb begin
    grant_d = grant_q;
    if (!contend) begin
      grant_d = GNT_NONE;
    end else if (grant_q == GNT_NONE) begin
      if (l_steady && !r_steady)      grant_d = GNT_LEFT;
      else if (r_steady && !l_steady) grant_d = GNT_RIGHT;
      else                            grant_d = TIE_GNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= GNT_NONE;
    else        grant_q <= grant_d;
  end

  // R2: the port already present (earlier select or earlier address) wins
  p_left_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (contend && grant_q == GNT_NONE && l_steady && !r_steady) |=> grant_q == GNT_LEFT);
  // R3: same rule seen from the right side
  p_right_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (contend && grant_q == GNT_NONE && r_steady && !l_steady) |=> grant_q == GNT_RIGHT);
  // R7: simultaneous arrival resolves to the fixed side
  p_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (contend && grant_q == GNT_NONE && (l_steady == r_steady)) |=> grant_q == TIE_GNT);
  // R5: decision holds while contention lasts
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (contend && grant_q != GNT_NONE) |=> $stable(grant_q));
endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter bit TIE_RIGHT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_act,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_act,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              win_valid,
  output logic              win_right
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]        en_v, act_v, live_v, steady_v;
  logic [ADDR_W-1:0]       addr_v [NPORT];
  logic                    contend;
  grant_e                  grant_q;

  always_comb begin
    en_v[0]   = l_en;   en_v[1]   = r_en;
    act_v[0]  = l_act;  act_v[1]  = r_act;
    addr_v[0] = l_addr; addr_v[1] = r_addr;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    busy_arb_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_v[p]),
      .act    (act_v[p]),
      .addr   (addr_v[p]),
      .live   (live_v[p]),
      .steady (steady_v[p])
    );
  end

  always_comb contend = live_v[0] & live_v[1] & (addr_v[0] == addr_v[1]);

  busy_arb_grant #(.TIE_RIGHT(TIE_RIGHT)) u_grant (
    .clk      (clk),
    .rst_n    (rst_n),
    .contend  (contend),
    .l_steady (steady_v[0]),
    .r_steady (steady_v[1]),
    .grant_q  (grant_q)
  );

  always_comb begin
    l_busy_n  = (grant_q != GNT_RIGHT);
    r_busy_n  = (grant_q != GNT_LEFT);
    win_valid = (grant_q != GNT_NONE);
    win_right = (grant_q == GNT_RIGHT);
  end

  // R1 / R6: no contention this cycle means both flags high next cycle
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && l_act && r_en && r_act && l_addr == r_addr) |=> (l_busy_n && r_busy_n));
  // R4: never both flags low
  p_one_loser_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));
  // R4: a flag only falls after a cycle of contention
  p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_busy_n) |-> $past(contend));
  // R10: indicator follows the low flag
  p_win_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_right == !l_busy_n));
endmodule

// File: tb/busy_arbiter_tb.sv
module busy_arbiter_tb;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          l_en, l_act, r_en, r_act;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_busy_n, r_busy_n, win_valid, win_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state: 0 none, 1 left, 2 right
  int            m_gnt;
  logic          m_llive, m_rlive;
  logic [AW-1:0] m_laddr, m_raddr;

  always #4 clk = ~clk;

  busy_arbiter #(.ADDR_W(AW), .TIE_RIGHT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_act(l_act), .l_addr(l_addr),
    .r_en(r_en), .r_act(r_act), .r_addr(r_addr),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .win_valid(win_valid), .win_right(win_right)
  );

  function automatic int next_gnt(int g, logic ll, logic rl, logic [AW-1:0] la,
                                  logic [AW-1:0] ra, logic pl, logic pr,
                                  logic [AW-1:0] pla, logic [AW-1:0] pra);
    logic c, ls, rs;
    c  = ll && rl && (la == ra);
    ls = ll && pl && (pla == la);
    rs = rl && pr && (pra == ra);
    if (!c) return 0;
    if (g != 0) return g;
    if (ls && !rs) return 1;
    if (rs && !ls) return 2;
    return 1;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act_v, input logic [3:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {lb,rb,wv,wr} actual %b expected %b", tag, act_v, exp_v);
    end
  endtask

  // drive at negedge, let one edge pass, sample at the next negedge
  task automatic step(input logic le, input logic la, input int lad,
                      input logic re, input logic ra, input int rad);
    logic ll, rl;
    l_en = le; l_act = la; l_addr = AW'(lad);
    r_en = re; r_act = ra; r_addr = AW'(rad);
    @(posedge clk);
    ll = le && la; rl = re && ra;
    m_gnt = next_gnt(m_gnt, ll, rl, l_addr, r_addr, m_llive, m_rlive, m_laddr, m_raddr);
    m_llive = ll; m_rlive = rl;
    if (ll) m_laddr = l_addr;
    if (rl) m_raddr = r_addr;
    @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {l_busy_n, r_busy_n, win_valid, win_right};
  endfunction

  function automatic logic [3:0] model_outs();
    return {m_gnt != 2, m_gnt != 1, m_gnt != 0, m_gnt == 2};
  endfunction

  localparam logic [3:0] IDLE = 4'b1100;
  localparam logic [3:0] LWIN = 4'b1010;  // right busy, left granted
  localparam logic [3:0] RWIN = 4'b0111;  // left busy, right granted

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_gnt = 0; m_llive = 0; m_rlive = 0; m_laddr = '0; m_raddr = '0;
    rst_n = 1'b0;
    l_en = 0; l_act = 0; l_addr = '0; r_en = 0; r_act = 0; r_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset", outs(), IDLE);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after release", outs(), IDLE);

    // R2: left selects first, right joins on same address
    step(1,1,5, 0,0,5);  chk("R1 single port", outs(), IDLE);
    step(1,1,5, 1,1,5);  chk("R2 left earlier select", outs(), LWIN);
    step(1,1,5, 1,1,5);  chk("R5 hold", outs(), LWIN);
    step(1,1,5, 1,1,5);  chk("R5 hold again", outs(), LWIN);
    step(0,1,5, 1,1,5);  chk("R6 winner drops select", outs(), IDLE);
    // R2 mirror: right now present, left rejoins
    step(1,1,5, 1,1,5);  chk("R2 right earlier select", outs(), RWIN);
    step(1,1,5, 1,0,5);  chk("R6 winner drops active", outs(), IDLE);
    step(0,0,0, 0,0,0);  chk("R1 all idle", outs(), IDLE);

    // R3: both live on different addresses, right moves onto left
    step(1,1,5, 1,1,6);  chk("R1 different addresses", outs(), IDLE);
    step(1,1,5, 1,1,5);  chk("R3 left address first", outs(), LWIN);
    step(1,1,7, 1,1,5);  chk("R6 winner moves address", outs(), IDLE);
    step(1,1,5, 1,1,5);  chk("R3 right address first", outs(), RWIN);
    step(1,1,5, 1,1,5);  chk("R10 right indicator held", outs(), RWIN);
    step(1,1,5, 1,1,9);  chk("R6 right moves away", outs(), IDLE);

    // R7: simultaneous arrivals
    step(0,0,0, 0,0,0);
    step(1,1,9, 1,1,9);  chk("R7 same-cycle select tie", outs(), LWIN);
    step(1,1,3, 1,1,4);  chk("R1 split after tie", outs(), IDLE);
    step(1,1,2, 1,1,2);  chk("R7 both addresses move together", outs(), LWIN);

    // R9: access-active low excludes the port
    step(0,0,0, 0,0,0);
    step(1,0,9, 1,1,9);  chk("R9 left not active", outs(), IDLE);
    step(1,0,9, 1,1,9);  chk("R9 still not active", outs(), IDLE);
    step(1,1,9, 1,1,9);  chk("R2 right earlier after R9", outs(), RWIN);
    step(0,0,0, 0,0,0);  chk("R6 both leave", outs(), IDLE);

    // random phase against the bench model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic le, la, re, ra;
      int lad, rad;
      le = ($urandom % 4) != 0; la = ($urandom % 5) != 0;
      re = ($urandom % 4) != 0; ra = ($urandom % 5) != 0;
      lad = $urandom % 3; rad = $urandom % 3;
      step(le, la, lad, re, ra, rad);
      chk("R4 R5 random vs model", outs(), model_outs());
      if (!l_busy_n && !r_busy_n) begin
        checks++; errors++;
        $display("FAIL R4: both busy low actual 00 expected not 00");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule